// File: doc/BRIEF.md
# Missed Frame Diagnostic Counter

This block keeps two diagnostic tallies of receive frames that an Ethernet DMA had to throw away. One tally counts frames lost because the host had no receive buffer ready. The other counts frames lost because the receive FIFO overflowed, together with runt frames that the FIFO layer discarded. Each tally has a sticky flag that records a wrap past its maximum value. Both tallies and both flags sit in one 32-bit status word. Reading that word clears every field.

The two drop sources deliver single-cycle pulses, and every cycle with a pulse counts one frame. Software reads the word by raising a read strobe for one clock cycle. The read data comes straight from the registers and is valid in that same cycle, so there is no handshake and no back-pressure. The read strobe, the drop pulses and the read data are plain control and status pins, not a stream.

Top module: `rx_miss_counter`

## Requirements
- R1: After reset, every bit of `rd_data_o` is 0.
- R2: Each cycle in which `buf_miss_i` is high and `rd_en_i` is low adds one to the buffer-miss count in bits 15:0.
- R3: Each cycle in which `fifo_miss_i` is high and `rd_en_i` is low adds one to the FIFO-miss count in bits 27:17.
- R4: When the buffer-miss count is 0xFFFF and a buffer miss arrives with no read, the count becomes 0 and bit 16 is set to 1.
- R5: When the FIFO-miss count is 0x7FF and a FIFO miss arrives with no read, the count becomes 0 and bit 28 is set to 1.
- R6: Bits 31:29 of `rd_data_o` are always 0.
- R7: `rd_data_o` always shows the current state of the fields. A read is a cycle with `rd_en_i` high. At the clock edge that ends a read with no drop pulse, both counts and both flags become 0.
- R8: If a drop pulse arrives in a read cycle, the read data shows the value from before the pulse. After the edge, that source's count is 1 and its flag is 0.
- R9: If both drop pulses arrive in the same cycle, each count is incremented. Neither source changes the other's count or flag.
- R10: A wrap flag stays at 1 through any number of further drop events until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_miss_i | input | 1 | One-cycle pulse for each frame lost because no host buffer was free |
| fifo_miss_i | input | 1 | One-cycle pulse for each frame lost to FIFO overflow or runt discard |
| rd_en_i | input | 1 | Read strobe; clears all fields at the end of the cycle |
| rd_data_o | output | 32 | Packed status word: buffer count 15:0, buffer wrap flag 16, FIFO count 27:17, FIFO wrap flag 28, 31:29 zero |

## Verification
The buffer-miss wrap is the hardest case to reach from the ports. The 16-bit tally must see 65,536 drop pulses with no read in between before bit 16 can go high. The stimulus holds `buf_miss_i` high for 65,535 cycles in a row and checks that the count sits at its maximum with the flag still clear. It then applies one more pulse and checks the wrap, and applies further pulses to show the flag stays set. A read that lands in the same cycle as drop pulses is driven on purpose, to check both the value returned and the count of 1 left behind.

// File: rtl/rx_miss_pkg.sv
package rx_miss_pkg;
  localparam int unsigned STAT_W = 32;
  typedef logic [STAT_W-1:0] stat_word_t;
endpackage

// File: rtl/miss_tally.sv
module miss_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      // read clears, but a coincident hit is kept as the first new event
      cnt_q  <= hit_i ? CNT_ONE : '0;
      wrap_q <= 1'b0;
    end else if (hit_i) begin
      cnt_q <= at_max ? '0 : cnt_q + CNT_ONE;
      if (at_max) wrap_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/stat_packer.sv
module stat_packer
  import rx_miss_pkg::*;
#(
  parameter int unsigned BUF_W  = 16,
  parameter int unsigned FIFO_W = 11
) (
  input  logic [BUF_W-1:0]  buf_cnt_i,
  input  logic              buf_wrap_i,
  input  logic [FIFO_W-1:0] fifo_cnt_i,
  input  logic              fifo_wrap_i,
  output stat_word_t        word_o
);
  localparam int unsigned BUF_FLAG_POS  = BUF_W;
  localparam int unsigned FIFO_LO       = BUF_W + 1;
  localparam int unsigned FIFO_FLAG_POS = BUF_W + FIFO_W + 1;

  always_comb begin
    word_o = '0;
    word_o[BUF_W-1:0]                 = buf_cnt_i;
    word_o[BUF_FLAG_POS]              = buf_wrap_i;
    word_o[FIFO_LO +: FIFO_W]         = fifo_cnt_i;
    word_o[FIFO_FLAG_POS]             = fifo_wrap_i;
  end
endmodule

// File: rtl/rx_miss_counter.sv
module rx_miss_counter
  import rx_miss_pkg::*;
#(
  parameter int unsigned BUF_W  = 16,
  parameter int unsigned FIFO_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_miss_i,
  input  logic              fifo_miss_i,
  input  logic              rd_en_i,
  output logic [STAT_W-1:0] rd_data_o
);
  localparam int unsigned USED_W = BUF_W + FIFO_W + 2;

  logic [BUF_W-1:0]  buf_cnt;
  logic              buf_wrap;
  logic [FIFO_W-1:0] fifo_cnt;
  logic              fifo_wrap;
  stat_word_t        word;

  generate
    if (USED_W > STAT_W) begin : g_bad_layout
      initial $error("rx_miss_counter: fields exceed status word");
    end
  endgenerate

  miss_tally #(.CNT_W(BUF_W)) buf_tally_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (buf_miss_i),
    .clr_i  (rd_en_i),
    .cnt_o  (buf_cnt),
    .wrap_o (buf_wrap)
  );

  miss_tally #(.CNT_W(FIFO_W)) fifo_tally_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (fifo_miss_i),
    .clr_i  (rd_en_i),
    .cnt_o  (fifo_cnt),
    .wrap_o (fifo_wrap)
  );

  stat_packer #(.BUF_W(BUF_W), .FIFO_W(FIFO_W)) packer_i (
    .buf_cnt_i   (buf_cnt),
    .buf_wrap_i  (buf_wrap),
    .fifo_cnt_i  (fifo_cnt),
    .fifo_wrap_i (fifo_wrap),
    .word_o      (word)
  );

  assign rd_data_o = word;
endmodule

// File: rtl/rx_miss_counter_chk.sv
module rx_miss_counter_chk #(
  parameter int unsigned BUF_W  = 16,
  parameter int unsigned FIFO_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        buf_miss_i,
  input logic        fifo_miss_i,
  input logic        rd_en_i,
  input logic [31:0] rd_data_o
);
  localparam int unsigned RSV_LO = BUF_W + FIFO_W + 2;
  localparam logic [BUF_W-1:0]  BMAX = {BUF_W{1'b1}};
  localparam logic [FIFO_W-1:0] FMAX = {FIFO_W{1'b1}};

  logic [BUF_W-1:0]  b_cnt;
  logic              b_flag;
  logic [FIFO_W-1:0] f_cnt;
  logic              f_flag;

  assign b_cnt  = rd_data_o[BUF_W-1:0];
  assign b_flag = rd_data_o[BUF_W];
  assign f_cnt  = rd_data_o[BUF_W+1 +: FIFO_W];
  assign f_flag = rd_data_o[BUF_W+FIFO_W+1];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o >> RSV_LO) == 32'd0);  // R6

  AST_BUF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && buf_miss_i && b_cnt != BMAX) |=> b_cnt == $past(b_cnt) + 1'b1);  // R2

  AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && fifo_miss_i && f_cnt != FMAX) |=> f_cnt == $past(f_cnt) + 1'b1);  // R3

  AST_BUF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && buf_miss_i && b_cnt == BMAX) |=> (b_cnt == '0 && b_flag));  // R4

  AST_FIFO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && fifo_miss_i && f_cnt == FMAX) |=> (f_cnt == '0 && f_flag));  // R5

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !buf_miss_i && !fifo_miss_i) |=> rd_data_o == 32'd0);  // R7

  AST_READ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && buf_miss_i) |=> (b_cnt == 1 && !b_flag));  // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && (b_flag || f_flag)) |=> ((b_flag || !$past(b_flag)) && (f_flag || !$past(f_flag))));  // R10

  AST_SIDE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !fifo_miss_i) |=> (f_cnt == $past(f_cnt) && f_flag == $past(f_flag)));  // R9
endmodule

bind rx_miss_counter rx_miss_counter_chk #(.BUF_W(BUF_W), .FIFO_W(FIFO_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .buf_miss_i  (buf_miss_i),
  .fifo_miss_i (fifo_miss_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/rx_miss_counter_tb_top.sv
module rx_miss_counter_tb_top;
  localparam int BMAX = 65535;
  localparam int FMAX = 2047;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_miss = 1'b0;
  logic        fifo_miss = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  int  m_bc = 0, m_fc = 0;
  bit  m_bf = 0, m_ff = 0;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  rx_miss_counter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_miss_i  (buf_miss),
    .fifo_miss_i (fifo_miss),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[15:0]  = m_bc[15:0];
    w[16]    = m_bf;
    w[27:17] = m_fc[10:0];
    w[28]    = m_ff;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; inputs change only after a falling edge
  task automatic step(input logic b, input logic f, input logic r);
    buf_miss = b; fifo_miss = f; rd_en = r;
    #1;
    last_rd = rd_data;
    @(posedge clk);
    if (r) begin
      m_bc = b ? 1 : 0; m_bf = 0;
      m_fc = f ? 1 : 0; m_ff = 0;
    end else begin
      if (b) begin
        if (m_bc == BMAX) begin m_bc = 0; m_bf = 1; end else m_bc++;
      end
      if (f) begin
        if (m_fc == FMAX) begin m_fc = 0; m_ff = 1; end else m_fc++;
      end
    end
    @(negedge clk);
    buf_miss = 0; fifo_miss = 0; rd_en = 0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 32'h0);
  endtask

  task automatic t_buf_count();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    check("R2 buffer count", rd_data, 32'h0000_0003);
    step(0, 0, 1);
    check("R7 read returns state", last_rd, 32'h0000_0003);
    check("R7 cleared after read", rd_data, 32'h0);
  endtask

  task automatic t_fifo_count();
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0);
      step(0, 0, 0);
    end
    check("R3 fifo count", rd_data, 32'd5 << 17);
    step(0, 0, 1);
    check("R7 cleared after fifo read", rd_data, 32'h0);
  endtask

  task automatic t_both();
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    step(1, 0, 0);
    check("R9 both sources", rd_data, (32'd4 << 17) | 32'd5);
    check("R9 model agree", rd_data, exp_word());
    step(0, 0, 1);
  endtask

  task automatic t_buf_wrap();
    for (int i = 0; i < BMAX; i++) step(1, 0, 0);
    check("R4 at maximum, no flag", rd_data, 32'h0000_FFFF);
    step(1, 0, 0);
    check("R4 wrap sets bit 16", rd_data, 32'h0001_0000);
    step(1, 0, 0);
    step(1, 0, 0);
    check("R10 flag held after more events", rd_data, 32'h0001_0002);
    step(0, 0, 1);
    check("R7 read returns flag", last_rd, 32'h0001_0002);
    check("R10 flag cleared by read", rd_data, 32'h0);
  endtask

  task automatic t_fifo_wrap();
    for (int i = 0; i < FMAX; i++) step(0, 1, 0);
    check("R5 at maximum, no flag", rd_data, 32'h0FFE_0000);
    step(1, 1, 0);
    check("R5 wrap sets bit 28", rd_data, 32'h1000_0001);
    check("R6 reserved bits zero", {29'h0, rd_data[31:29]}, 32'h0);
    step(0, 1, 0);
    check("R10 fifo flag held", rd_data, exp_word());
    step(0, 0, 1);
  endtask

  task automatic t_read_hit();
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 1, 1);
    check("R8 read shows pre-event value", last_rd, (32'd1 << 17) | 32'd2);
    check("R8 count left at one", rd_data, (32'd1 << 17) | 32'd1);
    step(0, 0, 1);
    check("R7 clear after hit read", rd_data, 32'h0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buf_count();
    t_fifo_count();
    t_both();
    t_buf_wrap();
    t_fifo_wrap();
    t_read_hit();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule